// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block holds the status and protection state behind the command port of a serial NOR flash. A front end that has already shifted in a command gives it one strobe when chip select rises. The strobe carries an opcode class, a 24-bit target address, the number of serial clock pulses counted during the frame, and a data byte for status writes. The block decides whether each modifying command may go ahead. If it may, it starts an abstract program/erase engine. It then keeps the busy state until the engine reports completion.

A modifying command (page program, sector erase, bulk erase, status write) starts only when all of these hold:
- the write-enable latch is set;
- the frame held a whole number of bytes;
- the target lies outside the top-of-array region that the block-protect field selects;
- for a status write, the status-lock bit together with a low write-protect pin does not freeze the protection bits.

A deep power-down state drops every command except its release. While the engine is busy, only status reads are served.

Top module: `flash_guard`

## Requirements
- R1: After reset, the status byte reads 00h (block-protect and lock bits take their reset parameters, 0 by default), dp_active is 0, and eng_start, reject and rd_valid are 0.
- R2: Write Enable sets the latch (status bit 1). Write Disable clears it. The completion (eng_done) of any accepted program, erase or status write also clears it.
- R3: Page Program, Sector Erase, Bulk Erase and Write Status are rejected when the latch is 0.
- R4: Those four commands are rejected unless cmd_bits is a nonzero multiple of eight.
- R5: With array size S = 2^21 bytes and protect field p, Page Program and Sector Erase are rejected under these conditions: p≥6 rejects every address; p in 1..5 rejects addresses ≥ S − S/2^(6−p); p=0 rejects none. An address ≥ S is always rejected.
- R6: Bulk Erase is rejected whenever the protect field is not 0.
- R7: When the lock bit (status bit 7) is 1 and wp_n is 0, Write Status is rejected. Otherwise an accepted Write Status copies cmd_wdata[4:2] to the protect field and cmd_wdata[7] to the lock bit when eng_done arrives.
- R8: An accepted command gives eng_start high for exactly one cycle, with eng_op equal to its opcode. Busy (status bit 0) is 1 from that cycle until the cycle after eng_done.
- R9: While busy, every command except Read Status has no effect, and no start or reject pulse follows it.
- R10: A rejected command gives reject high for exactly one cycle and leaves the latch unchanged.
- R11: Deep Power-down sets dp_active. While it is set, every command except Release has no effect, and Release clears it.
- R12: Read Status (when dp_active is 0, busy or not) gives rd_valid for one cycle, with rd_data equal to the status byte: bit0 busy, bit1 latch, bits 4:2 protect field, bits 6:5 zero, bit7 lock.
- R13: Opcode encoding on cmd_op: 0 Write Enable, 1 Write Disable, 2 Read Status, 3 Write Status, 4 Page Program, 5 Sector Erase, 6 Bulk Erase, 7 Deep Power-down, 8 Release, 9 Read Data (no effect). Every output reacts on the clock edge after cmd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_op | input | 4 | Opcode class (see R13) |
| cmd_addr | input | 24 | Target byte address |
| cmd_bits | input | 16 | Serial clock pulses counted in the frame |
| cmd_wdata | input | 8 | Data byte for Write Status |
| wp_n | input | 1 | Write-protect pin level |
| eng_done | input | 1 | Completion pulse from the program/erase engine |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_op | output | 4 | Opcode of the operation started |
| reject | output | 1 | One-cycle pulse for a rejected command |
| status | output | 8 | Live status byte |
| rd_valid | output | 1 | Read Status response strobe |
| rd_data | output | 8 | Status byte captured by Read Status |
| dp_active | output | 1 | Deep power-down state |

## Verification
The assertions assume that cmd_valid is a single-cycle strobe. They also assume that eng_done arrives only while busy, as a single pulse, and never in the same cycle as a command the block should act on. The bench drives every command as a one-cycle strobe at the falling edge. It raises eng_done only after it has seen a start pulse, and only when no command is in flight. The wp_n level is changed only between commands.

// File: rtl/fg_pkg.sv
package fg_pkg;
    typedef enum logic [3:0] {
        OP_WREN = 4'd0,
        OP_WRDI = 4'd1,
        OP_RDSR = 4'd2,
        OP_WRSR = 4'd3,
        OP_PP   = 4'd4,
        OP_SE   = 4'd5,
        OP_BE   = 4'd6,
        OP_DPD  = 4'd7,
        OP_RDP  = 4'd8,
        OP_READ = 4'd9
    } op_e;

    localparam int BP_W   = 3;
    localparam int BP_ALL = 6;
endpackage

// File: rtl/fg_region.sv
module fg_region #(
    parameter int ADDR_W = 24,
    parameter int ARR_W  = 21
) (
    input  logic [2:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              any_prot
);
    localparam logic [ARR_W:0] ARR_SIZE = {1'b1, {ARR_W{1'b0}}};

    logic [ARR_W:0] offs;
    logic [ARR_W:0] floor_addr;
    logic           beyond;
    logic [2:0]     shamt;

    always_comb begin
        offs       = {1'b0, addr[ARR_W-1:0]};
        beyond     = |addr[ADDR_W-1:ARR_W];
        shamt      = 3'(fg_pkg::BP_ALL) - bp;
        floor_addr = ARR_SIZE - (ARR_SIZE >> shamt);
        any_prot   = (bp != 3'd0);
        if (beyond) begin
            hit = 1'b1;
        end else if (bp == 3'd0) begin
            hit = 1'b0;
        end else if (bp >= 3'(fg_pkg::BP_ALL)) begin
            hit = 1'b1;
        end else begin
            hit = (offs >= floor_addr);
        end
    end
endmodule

// File: rtl/fg_frame.sv
module fg_frame #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] bits,
    output logic             whole
);
    always_comb begin
        whole = (bits[2:0] == 3'd0) && (bits != '0);
    end
endmodule

// File: rtl/flash_guard.sv
module flash_guard #(
    parameter int         ADDR_W    = 24,
    parameter int         ARR_W     = 21,
    parameter int         CNT_W     = 16,
    parameter logic [2:0] BP_RESET  = 3'd0,
    parameter logic       SRP_RESET = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [CNT_W-1:0]  cmd_bits,
    input  logic [7:0]        cmd_wdata,
    input  logic              wp_n,
    input  logic              eng_done,
    output logic              eng_start,
    output logic [3:0]        eng_op,
    output logic              reject,
    output logic [7:0]        status,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              dp_active
);
    import fg_pkg::*;

    typedef struct packed {
        logic            busy;
        logic            wel;
        logic [BP_W-1:0] bp;
        logic            srp;
        logic            pd;
        logic            pend_sr;
        logic [BP_W-1:0] pend_bp;
        logic            pend_srp;
        logic            start;
        logic [3:0]      op;
        logic            rej;
        logic            rdv;
        logic [7:0]      rdd;
    } st_t;

    st_t  st_d, st_q;
    op_e  op;
    logic hit, any_prot, whole, hpm, blocked, modifying;
    logic [7:0] sr_now;

    fg_region #(.ADDR_W(ADDR_W), .ARR_W(ARR_W)) region_i (
        .bp       (st_q.bp),
        .addr     (cmd_addr),
        .hit      (hit),
        .any_prot (any_prot)
    );

    fg_frame #(.CNT_W(CNT_W)) frame_i (
        .bits  (cmd_bits),
        .whole (whole)
    );

    always_comb begin
        op     = op_e'(cmd_op);
        sr_now = {st_q.srp, 2'b00, st_q.bp, st_q.wel, st_q.busy};
        hpm    = st_q.srp && !wp_n;
        modifying = (op == OP_WRSR) || (op == OP_PP) || (op == OP_SE) || (op == OP_BE);
        case (op)
            OP_PP, OP_SE: blocked = hit;
            OP_BE:        blocked = any_prot;
            OP_WRSR:      blocked = hpm;
            default:      blocked = 1'b0;
        endcase

        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.rej   = 1'b0;
        st_d.rdv   = 1'b0;

        if (eng_done && st_q.busy) begin
            st_d.busy    = 1'b0;
            st_d.wel     = 1'b0;
            st_d.pend_sr = 1'b0;
            if (st_q.pend_sr) begin
                st_d.bp  = st_q.pend_bp;
                st_d.srp = st_q.pend_srp;
            end
        end

        if (cmd_valid) begin
            if (st_q.pd) begin
                if (op == OP_RDP) st_d.pd = 1'b0;
            end else if (op == OP_RDSR) begin
                st_d.rdv = 1'b1;
                st_d.rdd = sr_now;
            end else if (!st_q.busy) begin
                if (modifying) begin
                    if (st_q.wel && whole && !blocked) begin
                        st_d.start = 1'b1;
                        st_d.busy  = 1'b1;
                        st_d.op    = cmd_op;
                        if (op == OP_WRSR) begin
                            st_d.pend_sr  = 1'b1;
                            st_d.pend_bp  = cmd_wdata[4:2];
                            st_d.pend_srp = cmd_wdata[7];
                        end
                    end else begin
                        st_d.rej = 1'b1;
                    end
                end else begin
                    case (op)
                        OP_WREN: st_d.wel = 1'b1;
                        OP_WRDI: st_d.wel = 1'b0;
                        OP_DPD:  st_d.pd  = 1'b1;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.bp       <= BP_RESET;
            st_q.srp      <= SRP_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign eng_start = st_q.start;
    assign eng_op    = st_q.op;
    assign reject    = st_q.rej;
    assign status    = sr_now;
    assign rd_valid  = st_q.rdv;
    assign rd_data   = st_q.rdd;
    assign dp_active = st_q.pd;
endmodule

// File: rtl/fg_guard_chk.sv
module fg_guard_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [3:0]       cmd_op,
    input logic [CNT_W-1:0] cmd_bits,
    input logic             wp_n,
    input logic             eng_done,
    input logic             eng_start,
    input logic             reject,
    input logic [7:0]       status,
    input logic             dp_active
);
    p_start_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> $past(status[1]));

    p_start_whole_bytes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> $past(cmd_bits[2:0] == 3'd0));

    p_start_sets_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> status[0]);

    p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !eng_done) |=> status[0]);

    p_done_clears_wel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && status[0]) |=> (!status[1] && !status[0]));

    p_reject_keeps_wel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> (status[1] == $past(status[1])));

    p_start_reject_apart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(eng_start && reject));

    p_busy_no_new_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && cmd_valid) |=> (!eng_start && !reject));

    p_pd_drops_cmds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_active && cmd_valid && cmd_op != 4'd8) |=>
            ($stable(status) && dp_active && !eng_start && !reject));

    p_locked_sr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] && !wp_n && cmd_valid && cmd_op == 4'd3 && !status[0] && !dp_active)
            |=> !eng_start);
endmodule

bind flash_guard fg_guard_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_bits  (cmd_bits),
    .wp_n      (wp_n),
    .eng_done  (eng_done),
    .eng_start (eng_start),
    .reject    (reject),
    .status    (status),
    .dp_active (dp_active)
);

// File: tb/flash_guard_tb_top.sv
`timescale 1ns/1ps
module flash_guard_tb_top;
    localparam int ADDR_W = 24;
    localparam int CNT_W  = 16;
    localparam int S      = 32'h20_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [3:0]        cmd_op = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [CNT_W-1:0]  cmd_bits = '0;
    logic [7:0]        cmd_wdata = '0;
    logic              wp_n = 1'b1;
    logic              eng_done = 1'b0;
    logic              eng_start, reject, rd_valid, dp_active;
    logic [3:0]        eng_op;
    logic [7:0]        status, rd_data;

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    always #2.5 clk = ~clk;

    flash_guard dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_bits(cmd_bits), .cmd_wdata(cmd_wdata),
        .wp_n(wp_n), .eng_done(eng_done), .eng_start(eng_start), .eng_op(eng_op),
        .reject(reject), .status(status), .rd_valid(rd_valid), .rd_data(rd_data),
        .dp_active(dp_active)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [3:0] op, input logic [23:0] addr,
                        input int bits, input logic [7:0] data);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr;
        cmd_bits = CNT_W'(bits); cmd_wdata = data;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic finish_op();
        @(negedge clk);
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    task automatic try_op(input string tag, input logic [3:0] op, input logic [23:0] addr,
                          input bit accept);
        send(4'd0, 0, 8, 0);
        send(op, addr, 32, 0);
        chk({tag, " start"}, eng_start, accept);
        chk({tag, " reject"}, reject, !accept);
        if (accept) begin
            chk({tag, " eng_op R8"}, eng_op, op);
            finish_op();
        end
    endtask

    task automatic set_sr(input logic [7:0] data);
        send(4'd0, 0, 8, 0);
        send(4'd3, 0, 16, data);
        chk("R7 wrsr start", eng_start, 1);
        finish_op();
        chk("R7 wrsr applied", status, {data[7], 2'b00, data[4:2], 2'b00});
    endtask

    task automatic t_reset();
        chk("R1 status", status, 8'h00);
        chk("R1 dp_active", dp_active, 0);
        chk("R1 pulses", {eng_start, reject, rd_valid}, 3'b000);
    endtask

    task automatic t_latch();
        send(4'd4, 24'h000100, 40, 0);
        chk("R3 no wel reject", reject, 1);
        chk("R3 no start", eng_start, 0);
        send(4'd0, 0, 8, 0);
        chk("R2 wren", status, 8'h02);
        send(4'd1, 0, 8, 0);
        chk("R2 wrdi", status, 8'h00);
    endtask

    task automatic t_frame_and_busy();
        send(4'd0, 0, 8, 0);
        send(4'd4, 24'h000100, 39, 0);
        chk("R4 odd bits reject", reject, 1);
        chk("R10 wel kept", status, 8'h02);
        @(negedge clk);
        chk("R10 reject one cycle", reject, 0);
        send(4'd5, 24'h000000, 0, 0);
        chk("R4 zero bits reject", reject, 1);
        send(4'd4, 24'h000100, 40, 0);
        chk("R8 start", eng_start, 1);
        chk("R8 eng_op", eng_op, 4'd4);
        chk("R8 busy", status, 8'h03);
        @(negedge clk);
        chk("R8 start one cycle", eng_start, 0);
        send(4'd5, 24'h000000, 32, 0);
        chk("R9 busy ignores erase", {eng_start, reject}, 2'b00);
        send(4'd7, 0, 8, 0);
        chk("R9 busy ignores dpd", dp_active, 0);
        send(4'd1, 0, 8, 0);
        chk("R9 busy ignores wrdi", status, 8'h03);
        send(4'd2, 0, 8, 0);
        chk("R12 rdsr while busy valid", rd_valid, 1);
        chk("R12 rdsr while busy data", rd_data, 8'h03);
        @(negedge clk);
        chk("R12 rd_valid one cycle", rd_valid, 0);
        finish_op();
        chk("R2 done clears wel and busy", status, 8'h00);
    endtask

    task automatic t_region();
        for (int p = 1; p <= 5; p++) begin
            int edge_a;
            edge_a = S - (S >> (6 - p));
            set_sr({3'b000, 3'(p), 2'b00});
            try_op("R5 below region pp", 4'd4, 24'(edge_a - 1), 1);
            try_op("R5 at region pp", 4'd4, 24'(edge_a), 0);
            try_op("R5 at region se", 4'd5, 24'(edge_a), 0);
            try_op("R6 be with protect", 4'd6, 0, 0);
        end
        set_sr(8'b000_110_00);
        try_op("R5 p6 protects all", 4'd4, 0, 0);
        set_sr(8'b000_111_00);
        try_op("R5 p7 protects all", 4'd5, 0, 0);
        set_sr(8'h00);
        try_op("R5 p0 top sector ok", 4'd5, 24'h1F0000, 1);
        try_op("R5 beyond array", 4'd4, 24'h200000, 0);
        try_op("R6 be unprotected", 4'd6, 0, 1);
    endtask

    task automatic t_lock();
        set_sr(8'b100_010_00);
        wp_n = 1'b0;
        send(4'd0, 0, 8, 0);
        send(4'd3, 0, 16, 8'h00);
        chk("R7 locked wrsr reject", reject, 1);
        chk("R7 locked keeps bits", status, 8'h8A);
        wp_n = 1'b1;
        set_sr(8'h00);
    endtask

    task automatic t_power_down();
        send(4'd7, 0, 8, 0);
        chk("R11 dpd entered", dp_active, 1);
        send(4'd0, 0, 8, 0);
        chk("R11 wren dropped", status, 8'h00);
        send(4'd2, 0, 8, 0);
        chk("R11 rdsr dropped", rd_valid, 0);
        send(4'd9, 0, 8, 0);
        chk("R13 read in dpd", dp_active, 1);
        send(4'd8, 0, 8, 0);
        chk("R11 release", dp_active, 0);
        send(4'd2, 0, 8, 0);
        chk("R12 rdsr idle", {rd_valid, rd_data}, 9'h100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_frame_and_busy();
        t_region();
        t_lock();
        t_power_down();
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!ended) begin
            ended = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule